// File: doc/BRIEF.md
# DMA Channel Request Pacing Unit

This block sits beside one DMA channel and decides when that channel raises its request for internal bus ownership. It also watches how long the channel goes without ownership. A mode input selects one of two pacing schemes. In device-paced mode, the request follows the peripheral's DMA request line. In memory-paced mode, the request follows the channel's wait-count-zero condition.

A 3-bit selector takes a different meaning in each mode. In device-paced mode it chooses a stall-detection window. If the bus is released and not granted back within that window, a sticky stall flag is set. In memory-paced mode it chooses a back-off. After each release the channel holds its request low for a power-of-two number of clocks.

The block also combines three gated status sources into one level interrupt: error (which includes the stall flag), chain done and transfer done. The configuration inputs are expected to come from control bits that reset to zero. The arbiter and the data path are outside this block.

Top module: `dma_pace_unit`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `bus_req`, `stall_flag` and `chan_irq` are 0.
- R2: With `cfg_io_mode`=1, `bus_req` one clock later equals `chan_active & dev_req & not-owned`. Ownership starts on a `bus_grant` pulse and ends on a `bus_release` pulse; grant wins if both arrive together.
- R3: With `cfg_io_mode`=0 and `cfg_sel`=0, `bus_req` one clock later equals `chan_active & wait_zero & not-owned`, with no back-off.
- R4: With `cfg_io_mode`=0 and `cfg_sel`=k (1..7), a `bus_release` sampled at edge t keeps `bus_req` low through edge t+D−1 and lets it rise at edge t+D, where D = 8·2^k (16 up to 1024 clocks).
- R5: With `cfg_io_mode`=1 and `cfg_sel`=0, `stall_flag` never sets.
- R6: With `cfg_io_mode`=1 and `cfg_sel`=k (1..7), a release at edge t with no grant after it sets `stall_flag` at edge t+W+1, where W = (2^(2k+2)−1)·64 (960 for k=1, 4032 for k=2). The flag is still 0 after edge t+W.
- R7: A `bus_grant` restarts the stall measurement, so the window counts from the next release.
- R8: `stall_flag` holds until a `stall_clr` pulse clears it. A new stall in the same cycle as a clear wins.
- R9: `chan_irq` is the registered OR of three terms, visible one clock after the inputs: `en_err_irq & (err_end | stall_flag)`, `en_chain_irq & chain_end` and `en_xfer_irq & xfer_end`.
- R10: In memory-paced mode the stall flag never sets, whatever the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_io_mode | input | 1 | 1 = device-paced, 0 = memory-paced |
| cfg_sel | input | 3 | Stall window or back-off selector |
| en_err_irq | input | 1 | Error interrupt enable |
| en_chain_irq | input | 1 | Chain-done interrupt enable |
| en_xfer_irq | input | 1 | Transfer-done interrupt enable |
| chan_active | input | 1 | Channel is enabled and running |
| dev_req | input | 1 | Peripheral DMA request |
| wait_zero | input | 1 | Wait counter has reached zero |
| bus_grant | input | 1 | Pulse: bus ownership granted |
| bus_release | input | 1 | Pulse: bus ownership released after the current operation |
| err_end | input | 1 | Error-end status |
| chain_end | input | 1 | Chain-done status |
| xfer_end | input | 1 | Transfer-done status |
| stall_clr | input | 1 | Pulse: clear the stall flag |
| bus_req | output | 1 | Bus ownership request |
| stall_flag | output | 1 | Sticky stall status |
| chan_irq | output | 1 | Level channel interrupt |

## Verification
Each kind of bad internal state shows up at the ports, and the timing of the check pins it down:

- **Ownership tracking:** a stale ownership bit shows as a request one clock late or missing after a grant or release.
- **Back-off counter:** a wrong load value moves the first request edge by a whole power of two. Checking the cycle just before and the cycle of the expected edge exposes any offset of even one clock.
- **Stall timer:** a prescaler or window-mask fault moves the flag edge by 64 clocks or more. Checking both sides of edge t+W+1 catches it within one window.
- **Restart on grant:** a lost restart makes the flag rise about 500 clocks early.
- **Interrupt gating:** a gating error appears on `chan_irq` one clock after the enable or status changes.

// File: rtl/dma_pace_pkg.sv
package dma_pace_pkg;

    localparam int SEL_W  = 3;
    localparam int PRE_W  = 6;
    localparam int UNIT_W = 16;
    localparam int DLY_W  = 11;

    typedef struct packed {
        logic              armed;
        logic [PRE_W-1:0]  pre;
        logic [UNIT_W-1:0] units;
        logic              flag;
    } stall_st_t;

    // Window in 64-clock units: 2^(2k+2)-1
    function automatic logic [UNIT_W-1:0] window_mask(input logic [SEL_W-1:0] sel);
        logic [UNIT_W:0] m;
        m = (({{UNIT_W{1'b0}}, 1'b1}) << (2 * int'(sel) + 2)) - 1'b1;
        return m[UNIT_W-1:0];
    endfunction

    // Back-off in clocks: 8 * 2^k (16 .. 1024)
    function automatic logic [DLY_W-1:0] backoff_len(input logic [SEL_W-1:0] sel);
        return DLY_W'(8) << sel;
    endfunction

endpackage

// File: rtl/dma_pace_stall.sv
module dma_pace_stall
    import dma_pace_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             watch_en,
    input  logic [SEL_W-1:0] sel,
    input  logic             grant,
    input  logic             release_p,
    input  logic             clr,
    output logic             flag
);
    stall_st_t s_d, s_q;
    logic      hit;

    always_comb begin
        s_d = s_q;
        hit = s_q.armed && watch_en &&
              (s_q.units == window_mask(sel)) && (s_q.pre == '0);
        if (grant) begin
            s_d.armed = 1'b0;
            s_d.pre   = '0;
            s_d.units = '0;
        end else if (release_p) begin
            s_d.armed = 1'b1;
            s_d.pre   = '0;
            s_d.units = '0;
        end else if (hit) begin
            s_d.armed = 1'b0;
        end else if (s_q.armed) begin
            s_d.pre = s_q.pre + 1'b1;
            if (s_q.pre == '1 && s_q.units != '1)
                s_d.units = s_q.units + 1'b1;
        end
        if (hit)
            s_d.flag = 1'b1;
        else if (clr)
            s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;
endmodule

// File: rtl/dma_pace_backoff.sv
module dma_pace_backoff
    import dma_pace_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_mode,
    input  logic [SEL_W-1:0] sel,
    input  logic             release_p,
    output logic             hold_d
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (release_p && mem_mode && sel != '0)
            cnt_d = backoff_len(sel);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        hold_d = (cnt_d != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dma_pace_irq.sv
module dma_pace_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_err,
    input  logic en_chain,
    input  logic en_xfer,
    input  logic err_src,
    input  logic chain_src,
    input  logic xfer_src,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = (en_err & err_src) | (en_chain & chain_src) | (en_xfer & xfer_src);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/dma_pace_unit.sv
module dma_pace_unit
    import dma_pace_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_io_mode,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             en_err_irq,
    input  logic             en_chain_irq,
    input  logic             en_xfer_irq,
    input  logic             chan_active,
    input  logic             dev_req,
    input  logic             wait_zero,
    input  logic             bus_grant,
    input  logic             bus_release,
    input  logic             err_end,
    input  logic             chain_end,
    input  logic             xfer_end,
    input  logic             stall_clr,
    output logic             bus_req,
    output logic             stall_flag,
    output logic             chan_irq
);
    typedef struct packed {
        logic own;
        logic req;
    } top_st_t;

    top_st_t t_d, t_q;
    logic    hold_d;
    logic    stall_q;

    dma_pace_stall u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .watch_en  (cfg_io_mode && cfg_sel != '0),
        .sel       (cfg_sel),
        .grant     (bus_grant),
        .release_p (bus_release),
        .clr       (stall_clr),
        .flag      (stall_q)
    );

    dma_pace_backoff u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_mode  (!cfg_io_mode),
        .sel       (cfg_sel),
        .release_p (bus_release),
        .hold_d    (hold_d)
    );

    dma_pace_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_err    (en_err_irq),
        .en_chain  (en_chain_irq),
        .en_xfer   (en_xfer_irq),
        .err_src   (err_end | stall_q),
        .chain_src (chain_end),
        .xfer_src  (xfer_end),
        .irq       (chan_irq)
    );

    always_comb begin
        t_d = t_q;
        if (bus_grant)        t_d.own = 1'b1;
        else if (bus_release) t_d.own = 1'b0;
        if (cfg_io_mode)
            t_d.req = !t_d.own && chan_active && dev_req;
        else
            t_d.req = !t_d.own && chan_active && wait_zero && !hold_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_req    = t_q.req;
    assign stall_flag = stall_q;
endmodule

// File: rtl/dma_pace_chk.sv
module dma_pace_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_io_mode,
    input logic [2:0] cfg_sel,
    input logic       en_err_irq,
    input logic       en_chain_irq,
    input logic       en_xfer_irq,
    input logic       dev_req,
    input logic       bus_grant,
    input logic       stall_clr,
    input logic       bus_req,
    input logic       stall_flag,
    input logic       chan_irq
);
    a_r2_io_no_dev_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_io_mode && !dev_req |=> !bus_req);

    a_r2_grant_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |=> !bus_req);

    a_r5_sel0_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_io_mode && cfg_sel == 3'd0 && !stall_flag |=> !stall_flag);

    a_r8_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stall_flag && !stall_clr |=> stall_flag);

    a_r10_mem_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_io_mode && !stall_flag |=> !stall_flag);

    a_r9_irq_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_err_irq && !en_chain_irq && !en_xfer_irq |=> !chan_irq);
endmodule

bind dma_pace_unit dma_pace_chk u_chk (.*);

// File: tb/dma_pace_unit_tb.sv
module dma_pace_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_io_mode = 0, en_err_irq = 0, en_chain_irq = 0, en_xfer_irq = 0;
    logic [2:0] cfg_sel = 3'd0;
    logic chan_active = 0, dev_req = 0, wait_zero = 0, bus_grant = 0, bus_release = 0;
    logic err_end = 0, chain_end = 0, xfer_end = 0, stall_clr = 0;
    logic bus_req, stall_flag, chan_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_pace_unit u_dut (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_grant();
        bus_grant = 1; tick(1); bus_grant = 0;
    endtask

    task automatic pulse_release();
        bus_release = 1; tick(1); bus_release = 0;
    endtask

    task automatic t_reset();
        chk("R1 bus_req", bus_req, 1'b0);
        chk("R1 stall_flag", stall_flag, 1'b0);
        chk("R1 chan_irq", chan_irq, 1'b0);
        rst_n = 1; tick(2);
        chk("R1 bus_req after reset", bus_req, 1'b0);
        chk("R1 irq after reset", chan_irq, 1'b0);
    endtask

    task automatic t_io_req();
        cfg_io_mode = 1; cfg_sel = 0; chan_active = 1; dev_req = 1; tick(1);
        chk("R2 req follows dev", bus_req, 1'b1);
        dev_req = 0; tick(1);
        chk("R2 req drops", bus_req, 1'b0);
        dev_req = 1; bus_grant = 1; tick(1); bus_grant = 0;
        chk("R2 no req while owned", bus_req, 1'b0);
        pulse_release();
        chk("R2 req after release", bus_req, 1'b1);
        chan_active = 0; tick(1);
        chk("R2 inactive no req", bus_req, 1'b0);
        dev_req = 0;
    endtask

    task automatic t_mem_sel0();
        cfg_io_mode = 0; cfg_sel = 0; chan_active = 1; wait_zero = 1; tick(1);
        chk("R3 req on wait zero", bus_req, 1'b1);
        pulse_grant(); pulse_release();
        chk("R3 no back-off with sel 0", bus_req, 1'b1);
        wait_zero = 0; tick(1);
        chk("R3 no req when waiting", bus_req, 1'b0);
    endtask

    task automatic t_mem_delay(input logic [2:0] sel, input int dly);
        cfg_io_mode = 0; cfg_sel = sel; chan_active = 1; wait_zero = 1;
        pulse_grant();
        pulse_release();
        tick(dly - 1);
        chk("R4 req held during back-off", bus_req, 1'b0);
        tick(1);
        chk("R4 req at back-off end", bus_req, 1'b1);
        wait_zero = 0; tick(1);
    endtask

    task automatic t_stall(input logic [2:0] sel, input int win);
        cfg_io_mode = 1; cfg_sel = sel; chan_active = 0;
        pulse_grant();
        pulse_release();
        tick(win);
        chk("R6 no stall at window", stall_flag, 1'b0);
        tick(1);
        chk("R6 stall past window", stall_flag, 1'b1);
        tick(100);
        chk("R8 stall sticky", stall_flag, 1'b1);
        stall_clr = 1; tick(1); stall_clr = 0;
        chk("R8 stall cleared", stall_flag, 1'b0);
    endtask

    task automatic t_restart();
        cfg_io_mode = 1; cfg_sel = 1;
        pulse_grant(); pulse_release();
        tick(500);
        pulse_grant(); pulse_release();
        tick(960);
        chk("R7 grant restarts window", stall_flag, 1'b0);
        tick(1);
        chk("R7 stall after restarted window", stall_flag, 1'b1);
    endtask

    task automatic t_no_stall(input logic io, input string req);
        stall_clr = 1; tick(1); stall_clr = 0;
        cfg_io_mode = io; cfg_sel = io ? 3'd0 : 3'd1;
        pulse_grant(); pulse_release();
        tick(1100);
        chk(req, stall_flag, 1'b0);
    endtask

    task automatic t_irq();
        cfg_io_mode = 1; cfg_sel = 1;
        pulse_grant(); pulse_release(); tick(962);
        en_err_irq = 1; tick(1);
        chk("R9 stall raises error irq", chan_irq, 1'b1);
        en_err_irq = 0; tick(1);
        chk("R9 error irq gated", chan_irq, 1'b0);
        stall_clr = 1; tick(1); stall_clr = 0;
        err_end = 1; en_err_irq = 1; tick(1);
        chk("R9 err_end irq", chan_irq, 1'b1);
        err_end = 0; en_err_irq = 0; chain_end = 1; tick(1);
        chk("R9 chain gated off", chan_irq, 1'b0);
        en_chain_irq = 1; tick(1);
        chk("R9 chain irq", chan_irq, 1'b1);
        chain_end = 0; en_chain_irq = 0; xfer_end = 1; en_xfer_irq = 1; tick(1);
        chk("R9 xfer irq", chan_irq, 1'b1);
        en_xfer_irq = 0; tick(1);
        chk("R9 xfer gated off", chan_irq, 1'b0);
        xfer_end = 0;
    endtask

    initial begin
        tick(3);
        t_reset();
        t_io_req();
        t_mem_sel0();
        t_mem_delay(3'd1, 16);
        t_mem_delay(3'd3, 64);
        t_mem_delay(3'd7, 1024);
        t_stall(3'd1, 960);
        t_stall(3'd2, 4032);
        t_restart();
        t_no_stall(1'b1, "R5 sel 0 never stalls");
        t_no_stall(1'b0, "R10 memory mode never stalls");
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule